// File: doc/BRIEF.md
# Bidirectional Reset Pin Sequencer

The block manages an active-low, open-drain reset pin that an outside agent, or the chip itself, can pull low. A low level on the pin or a request from an internal reset source such as a watchdog or a clock monitor starts a reset sequence. The block then pulls the pin low itself for a fixed number of cycles and lets it go. A fixed number of cycles after letting go, it looks at the pin again. A pin that is still low means the reset came from outside. A pin that has returned high means the reset came from the highest-priority internal request that is pending.

The block drives the core reset for the whole sequence. It produces a pin pull-down enable for the pad, and a small source code that the vector fetch logic uses to pick a reset vector. Internal requests are captured in sticky flags, so a request that lasts one cycle is never missed. The pin passes through a synchronizer before any decision is taken. All cycle counts below are measured at the clock edges that this synchronized copy reaches.

Top module: `rstpin_seq`

## Requirements
- R1: While `rst` is high and after it is released, `drive_low_o` and `core_rst_o` are 0 and `src_o` is 2'b00 (no reset seen yet).
- R2: Take Ea as the first rising edge at which `rst_pin_i` is low while the block is idle. `drive_low_o` and `core_rst_o` both go high at edge Ea+2, after the two-stage synchronizer. A low pulse as short as one cycle starts a full sequence.
- R3: `drive_low_o` stays high for exactly 4 consecutive cycles per sequence and then drops.
- R4: The source is decided at the third edge after `drive_low_o` drops, using the synchronized pin level. A low level gives `src_o` = 2'b01 (external). An external low pulse of 8 or more cycles is therefore always coded 2'b01, even when an internal request is pending.
- R5: If the pin is high at the decision, `src_o` takes the code of the highest-priority pending request: 2'b10 for `req_i[0]`, which wins, and 2'b11 for `req_i[1]`. A 7-cycle external pulse with `req_i[1]` pending gives 2'b11.
- R6: If the pin is high at the decision and no internal request is pending, which happens after a short external pulse, `src_o` = 2'b01.
- R7: Internal requests are latched. A request that is high for one cycle, sampled at edge Er while the block is idle, starts a sequence at edge Er+1. A request that arrives during a sequence is kept until the decision of that sequence.
- R8: `core_rst_o` stays high from the start of the sequence through the decision, and falls one edge after the decision, which is 8 cycles in all.
- R9: A low pin level seen during the drive or wait phase does not restart the sequence. After the sequence ends, no new sequence starts unless the pin is low or a request is pending once the block is idle.
- R10: `src_o` changes only at a decision. It holds its value while idle and during the next sequence until that sequence's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_i | input | 1 | Level read back from the reset pin (0 = pin low) |
| req_i | input | NUM_REQ | Internal reset requests, bit 0 has highest priority |
| drive_low_o | output | 1 | Pull-down enable for the pin pad (1 = pull pin low) |
| core_rst_o | output | 1 | Reset to the rest of the chip, active high |
| src_o | output | 2 | Source code: 00 none, 01 external, 10 request 0, 11 request 1 |

## Verification
The bench aims at the classification boundary. An 8-cycle external pulse with a request pending must still be coded external, and a 7-cycle one must fall through to the request. A decision taken one cycle late or early would swap these two results. A one-cycle pulse checks that recognition works through the synchronizer; a design that sampled the raw pin or needed a longer pulse would miss it or start on the wrong edge. The bench also checks the following:
- The priority between two requests raised together.
- That a pin glitch during the wait phase alters the code but never starts a second sequence. A design without this guard would show a second pulse on `drive_low_o`.
- That the source code survives idle time and the early part of the next sequence.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  localparam int SRC_NONE     = 0;
  localparam int SRC_EXT      = 1;
  localparam int SRC_INT_BASE = 2;

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rstpin_reqlat.sv
module rstpin_reqlat #(
  parameter int NUM_REQ = 2,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               clr_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [NUM_REQ-1:0] pend;

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) pend[i] <= 1'b0;
        else     pend[i] <= req_i[i] | (pend[i] & ~clr_i);
      end
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int k = NUM_REQ - 1; k >= 0; k--) begin
      if (pend[k]) idx_o = IDX_W'(k);
    end
  end

  assign any_o = |pend;

endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
  import rstpin_pkg::*;
#(
  parameter int DRIVE_CYCLES = 4,
  parameter int WAIT_CYCLES  = 2,
  parameter int IDX_W        = 1,
  parameter int SRC_W        = 2,
  localparam int SAMPLE_EDGES = WAIT_CYCLES + 1,
  localparam int CNT_MAX      = (DRIVE_CYCLES > SAMPLE_EDGES) ? DRIVE_CYCLES : SAMPLE_EDGES,
  localparam int CNT_W        = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_lo_i,
  input  logic             any_pend_i,
  input  logic [IDX_W-1:0] pend_idx_i,
  output logic             clr_o,
  output logic             drive_o,
  output logic             core_o,
  output logic [SRC_W-1:0] src_o
);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             at_drive_end;
  logic             at_sample;
  logic [SRC_W-1:0] verdict;

  assign at_drive_end = (cnt == CNT_W'(DRIVE_CYCLES - 1));
  assign at_sample    = (state == ST_WAIT) && (cnt == CNT_W'(SAMPLE_EDGES - 1));
  assign clr_o        = at_sample;

  always_comb begin
    if (pin_lo_i || !any_pend_i) verdict = SRC_W'(SRC_EXT);
    else                         verdict = SRC_W'(SRC_INT_BASE) + SRC_W'(pend_idx_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      drive_o <= 1'b0;
      core_o  <= 1'b0;
      src_o   <= SRC_W'(SRC_NONE);
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pin_lo_i || any_pend_i) begin
            state   <= ST_DRIVE;
            cnt     <= '0;
            drive_o <= 1'b1;
            core_o  <= 1'b1;
          end
        end
        ST_DRIVE: begin
          if (at_drive_end) begin
            state   <= ST_WAIT;
            cnt     <= '0;
            drive_o <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (at_sample) begin
            state <= ST_DONE;
            cnt   <= '0;
            src_o <= verdict;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: begin
          state  <= ST_IDLE;
          core_o <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq #(
  parameter int NUM_REQ      = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int DRIVE_CYCLES = 4,
  parameter int WAIT_CYCLES  = 2,
  localparam int IDX_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int SRC_W       = $clog2(NUM_REQ + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_pin_i,
  input  logic [NUM_REQ-1:0] req_i,
  output logic               drive_low_o,
  output logic               core_rst_o,
  output logic [SRC_W-1:0]   src_o
);

  logic             pin_s;
  logic             any_pend;
  logic [IDX_W-1:0] pend_idx;
  logic             clr;

  rstpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rst_pin_i),
    .q_o (pin_s)
  );

  rstpin_reqlat #(.NUM_REQ(NUM_REQ)) u_req (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_i),
    .clr_i (clr),
    .any_o (any_pend),
    .idx_o (pend_idx)
  );

  rstpin_ctrl #(
    .DRIVE_CYCLES (DRIVE_CYCLES),
    .WAIT_CYCLES  (WAIT_CYCLES),
    .IDX_W        (IDX_W),
    .SRC_W        (SRC_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pin_lo_i   (~pin_s),
    .any_pend_i (any_pend),
    .pend_idx_i (pend_idx),
    .clr_o      (clr),
    .drive_o    (drive_low_o),
    .core_o     (core_rst_o),
    .src_o      (src_o)
  );

endmodule

// File: rtl/rstpin_seq_chk.sv
module rstpin_seq_chk #(
  parameter int DRIVE_CYCLES = 4,
  parameter int SRC_W        = 2,
  localparam int DC_W        = $clog2(DRIVE_CYCLES + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             drive_low_o,
  input logic             core_rst_o,
  input logic [SRC_W-1:0] src_o
);

  logic [DC_W-1:0] drv_cnt;

  always_ff @(posedge clk) begin
    if (rst)              drv_cnt <= '0;
    else if (drive_low_o) drv_cnt <= drv_cnt + 1'b1;
    else                  drv_cnt <= '0;
  end

  // R3
  drive_len_max_chk: assert property (@(posedge clk) disable iff (rst)
    drive_low_o |-> (drv_cnt < DC_W'(DRIVE_CYCLES)));

  // R3
  drive_len_exact_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_low_o) |-> (drv_cnt == DC_W'(DRIVE_CYCLES)));

  // R2
  drive_with_core_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low_o) |-> $rose(core_rst_o));

  // R8
  drive_inside_core_chk: assert property (@(posedge clk) disable iff (rst)
    drive_low_o |-> core_rst_o);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low_o) |-> !$past(core_rst_o));

  // R4
  src_decided_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> (src_o != '0));

  // R10
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!core_rst_o && !$past(core_rst_o)) |-> $stable(src_o));

endmodule

bind rstpin_seq rstpin_seq_chk #(.DRIVE_CYCLES(DRIVE_CYCLES), .SRC_W(SRC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .drive_low_o (drive_low_o),
  .core_rst_o  (core_rst_o),
  .src_o       (src_o)
);

// File: tb/sim_rstpin_seq.sv
module sim_rstpin_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_low = 1'b0;
  logic [1:0] req = 2'b00;
  logic       pin;
  logic       drive_low;
  logic       core_rst;
  logic [1:0] src;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign pin = !(ext_low || drive_low);

  rstpin_seq u0 (
    .clk         (clk),
    .rst         (rst),
    .rst_pin_i   (pin),
    .req_i       (req),
    .drive_low_o (drive_low),
    .core_rst_o  (core_rst),
    .src_o       (src)
  );

  // vector: {ext_len[4:0], req_mask[1:0], req_cycle[3:0], expected src[1:0]}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {5'd8, 2'b10, 4'd3, 2'b01},  // R4: 8-cycle pulse beats pending request 1
    {5'd7, 2'b10, 4'd3, 2'b11},  // R5: 7-cycle pulse yields to request 1
    {5'd1, 2'b00, 4'd0, 2'b01},  // R6: short pulse, nothing pending
    {5'd1, 2'b01, 4'd0, 2'b10},  // R5: short pulse with request 0
    {5'd0, 2'b11, 4'd0, 2'b10},  // R5: both requests, request 0 wins
    {5'd0, 2'b10, 4'd0, 2'b11},  // R7: request 1 alone
    {5'd9, 2'b01, 4'd2, 2'b01},  // R4: long pulse with request 0
    {5'd0, 2'b10, 4'd4, 2'b11}   // R7: late one-cycle request 1
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [12:0] v);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      ext_low = (c < int'(v[12:8]));
      req     = (c == int'(v[5:2])) ? v[7:6] : 2'b00;
    end
    @(negedge clk);
    check("R4/R5 src after vector", src, v[1:0]);
    check("R8 core released after vector", core_rst, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 drive during reset", drive_low, 0);
    check("R1 core during reset", core_rst, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 drive after reset", drive_low, 0);
    check("R1 core after reset", core_rst, 0);
    check("R1 src after reset", src, 0);

    // R2 R3 R8: one-cycle external pulse, cycle-exact timing
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (c >= 1) begin
        check("R2 R3 drive timing ext", drive_low, (c >= 3 && c <= 6) ? 1 : 0);
        check("R8 core timing ext", core_rst, (c >= 3 && c <= 10) ? 1 : 0);
      end
      if (c == 10) check("R6 src short pulse", src, 1);
      ext_low = (c == 0);
    end

    // R7: one-cycle internal request 0, cycle-exact timing
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (c >= 1) begin
        check("R7 drive timing int", drive_low, (c >= 2 && c <= 5) ? 1 : 0);
        check("R8 core timing int", core_rst, (c >= 2 && c <= 9) ? 1 : 0);
      end
      if (c == 9) check("R5 src request 0", src, 2);
      req = (c == 0) ? 2'b01 : 2'b00;
    end

    // vector table
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9: pin glitch in wait phase does not restart
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      if (c >= 7) check("R9 no second drive", drive_low, 0);
      if (c >= 11) check("R9 core stays released", core_rst, 0);
      ext_low = (c == 0) || (c == 7);
    end
    check("R9 src after glitch", src, 1);

    // R10: source held while idle and into the next sequence
    run_vec({5'd0, 2'b10, 4'd0, 2'b11});
    repeat (6) begin
      @(negedge clk);
      check("R10 src held idle", src, 3);
    end
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (c == 5) begin
        check("R10 core in next sequence", core_rst, 1);
        check("R10 src held before decision", src, 3);
      end
      ext_low = (c == 0);
    end
    check("R10 src after new decision", src, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule